// File: doc/BRIEF.md
# Predicated Integer Execute Unit

This block is the data-processing stage of a 32-bit load/store RISC core. Each cycle it may receive one instruction. That instruction carries a condition selector, an operation code, a set-flags request, a first operand and a second operand. The second operand is either a packed immediate, which is an 8-bit constant rotated right by an even amount, or a register value passed through a barrel shifter. The shift amount comes either from a 5-bit field or from the low byte of a further register.

The block first tests the condition against its internal NZCV flag register. If the test passes, it produces the result and a destination write strobe. It also updates the flags when the operation or the set-flags request calls for it. If the test fails, the instruction has no architectural effect. The result and the write strobe are combinational in the issue cycle. The flags are registered and show their new value from the next cycle on.

Top module: `pred_alu`

## Requirements
- R1: When `instValid` is 0, `writeEn` is 0 and the flags do not change on the following edge.
- R2: `condIn` picks a predicate on the current flags. 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C and !Z), 9 LS (!C or Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z and N==V), 13 LE (Z or N!=V), 14 AL (always), 15 never.
- R3: An instruction whose predicate is false leaves `writeEn` at 0 and leaves the flags unchanged.
- R4: `opcode` values 0..15 select, in this order: ADD, ADC, SUB, SBC, RSB (op2-op1), RSC (op2-op1 with carry), AND, ORR, EOR, BIC (op1 AND NOT op2), CMP, CMN, TST, TEQ, MOV (op2), MVN (NOT op2). MOV and MVN ignore `opA`.
- R5: CMP, CMN, TST and TEQ (opcodes 10..13) never assert `writeEn`. When their predicate passes they update the flags whatever `setFlags` is. They compute as SUB, ADD, AND and EOR respectively.
- R6: The other opcodes update the flags only when `setFlags` is 1.
- R7: The flags port is {N,Z,C,V} with N at bit 3. On an update, N is result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R8: For arithmetic opcodes, C is the carry out of bit 31, where a subtraction with no borrow gives C=1. V is the signed two's-complement overflow. The carry input of ADC, SBC and RSC is the current C.
- R9: For logical opcodes (AND, ORR, EOR, BIC, TST, TEQ, MOV, MVN), C takes the operand shifter's carry-out and V keeps its value.
- R10: When `useImm` is 1, the operand is `immField[7:0]` rotated right by 2*`immField[11:8]`. The shifter carry is the old C for a rotate of 0, and otherwise the operand's bit 31.
- R11: When `useImm` is 0, `opB` is shifted by `shiftType` (0 LSL, 1 LSR, 2 ASR, 3 ROR). The amount is `shiftImm` when `shiftByReg` is 0. An amount of 0 passes `opB` through with carry equal to the old C. A nonzero amount yields as carry the last bit shifted out.
- R12: When `shiftByReg` is 1, the amount is `shiftReg[7:0]`, 0..255, and the upper bits are ignored. For amounts of 32 and more: LSL gives 0 with carry `opB[0]` at exactly 32 and 0 above 32. LSR gives 0 with carry `opB[31]` at exactly 32 and 0 above 32. ASR fills with `opB[31]` and gives carry `opB[31]`. ROR rotates by the amount mod 32, and a multiple of 32 gives `opB` with carry `opB[31]`.
- R13: After reset the flags are 0000. `result` and `writeEn` are valid in the issue cycle, and new flags appear after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the flag register |
| instValid | input | 1 | An instruction is presented this cycle |
| condIn | input | 4 | Condition selector |
| opcode | input | 4 | Operation selector |
| setFlags | input | 1 | Request a flag update |
| opA | input | 32 | First operand |
| useImm | input | 1 | Second operand is the packed immediate |
| immField | input | 12 | Rotate count [11:8] and constant [7:0] |
| opB | input | 32 | Register value to be shifted |
| shiftType | input | 2 | Shift kind |
| shiftByReg | input | 1 | Take the shift amount from `shiftReg` |
| shiftImm | input | 5 | Immediate shift amount |
| shiftReg | input | 32 | Register supplying the amount in bits [7:0] |
| result | output | 32 | Operation result |
| writeEn | output | 1 | Destination register write strobe |
| flags | output | 4 | Current {N,Z,C,V} |

## Verification
The bench sweeps every predicate across many flag states. A wrong predicate decode shows up as a write strobe or flag change in the wrong cycle. It drives shift amounts of 0, 1, 31, 32, 33, 64 and 255 for every shift kind, because an off-by-one in the carry tap or in the handling of large amounts would corrupt C, or would wrap a large shift into a small one. Carry-in operations, reverse subtraction and overflow boundaries target a wrongly inverted borrow or a wrong overflow sign test. Compares issued with `setFlags` low check that flags still update while the write strobe stays low.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_RSB = 4'd4, OP_RSC = 4'd5, OP_AND = 4'd6, OP_ORR = 4'd7,
    OP_EOR = 4'd8, OP_BIC = 4'd9, OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_TST = 4'd12, OP_TEQ = 4'd13, OP_MOV = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
  } shiftKind_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0, CIN_ONE = 2'd1, CIN_FLAG = 2'd2
  } carrySel_e;

  typedef enum logic [2:0] {
    LF_AND = 3'd0, LF_ORR = 3'd1, LF_EOR = 3'd2, LF_BIC = 3'd3,
    LF_PASS = 3'd4, LF_INV = 3'd5
  } logicFn_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  typedef struct packed {
    logic      writeDest;
    logic      updateFlags;
    logic      useAdder;
    logic      swapOps;
    logic      invertB;
    carrySel_e carrySel;
    logicFn_e  logicFn;
  } aluStrobes_t;

endpackage

// File: rtl/pred_alu_ctrl.sv
module pred_alu_ctrl
  import pred_alu_pkg::*;
(
  input  logic        instValid,
  input  logic [3:0]  condIn,
  input  logic [3:0]  opcode,
  input  logic        setFlags,
  input  logic [3:0]  flagsQ,
  output aluStrobes_t strobes
);

  logic condPass;
  logic isCompare;
  logic writesDest;
  logic fN, fZ, fC, fV;

  assign fN = flagsQ[FLAG_N];
  assign fZ = flagsQ[FLAG_Z];
  assign fC = flagsQ[FLAG_C];
  assign fV = flagsQ[FLAG_V];

  always_comb begin
    unique case (condIn)
      4'd0:    condPass = fZ;
      4'd1:    condPass = !fZ;
      4'd2:    condPass = fC;
      4'd3:    condPass = !fC;
      4'd4:    condPass = fN;
      4'd5:    condPass = !fN;
      4'd6:    condPass = fV;
      4'd7:    condPass = !fV;
      4'd8:    condPass = fC && !fZ;
      4'd9:    condPass = !fC || fZ;
      4'd10:   condPass = (fN == fV);
      4'd11:   condPass = (fN != fV);
      4'd12:   condPass = !fZ && (fN == fV);
      4'd13:   condPass = fZ || (fN != fV);
      4'd14:   condPass = 1'b1;
      default: condPass = 1'b0;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.carrySel = CIN_ZERO;
    strobes.logicFn  = LF_AND;
    isCompare        = 1'b0;
    writesDest       = 1'b1;
    unique case (aluOp_e'(opcode))
      OP_ADD: strobes.useAdder = 1'b1;
      OP_ADC: begin strobes.useAdder = 1'b1; strobes.carrySel = CIN_FLAG; end
      OP_SUB: begin strobes.useAdder = 1'b1; strobes.invertB = 1'b1; strobes.carrySel = CIN_ONE; end
      OP_SBC: begin strobes.useAdder = 1'b1; strobes.invertB = 1'b1; strobes.carrySel = CIN_FLAG; end
      OP_RSB: begin
        strobes.useAdder = 1'b1; strobes.swapOps = 1'b1;
        strobes.invertB = 1'b1; strobes.carrySel = CIN_ONE;
      end
      OP_RSC: begin
        strobes.useAdder = 1'b1; strobes.swapOps = 1'b1;
        strobes.invertB = 1'b1; strobes.carrySel = CIN_FLAG;
      end
      OP_AND: strobes.logicFn = LF_AND;
      OP_ORR: strobes.logicFn = LF_ORR;
      OP_EOR: strobes.logicFn = LF_EOR;
      OP_BIC: strobes.logicFn = LF_BIC;
      OP_CMP: begin
        strobes.useAdder = 1'b1; strobes.invertB = 1'b1; strobes.carrySel = CIN_ONE;
        isCompare = 1'b1; writesDest = 1'b0;
      end
      OP_CMN: begin strobes.useAdder = 1'b1; isCompare = 1'b1; writesDest = 1'b0; end
      OP_TST: begin strobes.logicFn = LF_AND; isCompare = 1'b1; writesDest = 1'b0; end
      OP_TEQ: begin strobes.logicFn = LF_EOR; isCompare = 1'b1; writesDest = 1'b0; end
      OP_MOV: strobes.logicFn = LF_PASS;
      OP_MVN: strobes.logicFn = LF_INV;
      default: strobes.logicFn = LF_AND;
    endcase
    strobes.writeDest   = instValid && condPass && writesDest;
    strobes.updateFlags = instValid && condPass && (setFlags || isCompare);
  end

endmodule

// File: rtl/pred_alu_shifter.sv
module pred_alu_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value,
  input  logic [AMT_W-1:0]  amount,
  input  logic [1:0]        kind,
  input  logic              carryIn,
  output logic [DATA_W-1:0] shifted,
  output logic              carryOut
);
  import pred_alu_pkg::*;

  localparam int unsigned CL_W = $clog2(DATA_W + 2);
  localparam int unsigned RA_W = $clog2(DATA_W);

  logic [CL_W-1:0]          amtClamp;
  logic [DATA_W:0]          lslExt;
  logic [DATA_W:0]          lsrExt;
  logic signed [DATA_W:0]   asrExt;
  logic [RA_W-1:0]          rotAmt;
  logic [RA_W:0]            rotComp;
  logic [DATA_W-1:0]        rorVal;

  // Amounts past DATA_W all behave like DATA_W+1 for the linear shifts.
  assign amtClamp = (amount > AMT_W'(DATA_W)) ? CL_W'(DATA_W + 1) : amount[CL_W-1:0];

  assign lslExt  = {1'b0, value} << amtClamp;
  assign lsrExt  = {value, 1'b0} >> amtClamp;
  assign asrExt  = $signed({value, 1'b0}) >>> amtClamp;
  assign rotAmt  = amount[RA_W-1:0];
  assign rotComp = (RA_W+1)'(DATA_W) - {1'b0, rotAmt};
  assign rorVal  = (value >> rotAmt) | (value << rotComp);

  always_comb begin
    shifted  = value;
    carryOut = carryIn;
    if (amount != '0) begin
      unique case (shiftKind_e'(kind))
        SH_LSL: begin shifted = lslExt[DATA_W-1:0]; carryOut = lslExt[DATA_W]; end
        SH_LSR: begin shifted = lsrExt[DATA_W:1];   carryOut = lsrExt[0]; end
        SH_ASR: begin shifted = asrExt[DATA_W:1];   carryOut = asrExt[0]; end
        SH_ROR: begin shifted = rorVal;             carryOut = rorVal[DATA_W-1]; end
        default: begin shifted = value; carryOut = carryIn; end
      endcase
    end
  end

endmodule

// File: rtl/pred_alu_dp.sv
module pred_alu_dp
  import pred_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROT_W  = 4,
  parameter int unsigned CONST_W = 8,
  parameter int unsigned SIMM_W = 5,
  parameter int unsigned AMT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  aluStrobes_t               strobes,
  input  logic [DATA_W-1:0]         opA,
  input  logic                      useImm,
  input  logic [ROT_W+CONST_W-1:0]  immField,
  input  logic [DATA_W-1:0]         opB,
  input  logic [1:0]                shiftType,
  input  logic                      shiftByReg,
  input  logic [SIMM_W-1:0]         shiftImm,
  input  logic [DATA_W-1:0]         shiftReg,
  output logic [DATA_W-1:0]         result,
  output logic [3:0]                flagsQ
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] shInValue;
  logic [AMT_W-1:0]  shAmount;
  logic [1:0]        shKind;
  logic [DATA_W-1:0] operand2;
  logic              shCarry;
  logic [DATA_W-1:0] addX, addY;
  logic              addCin;
  logic [DATA_W:0]   sum;
  logic              ovf;
  logic [DATA_W-1:0] logicRes;
  logic              newC, newV;
  logic [3:0]        flagsD;
  logic              unusedRegHigh;

  assign unusedRegHigh = ^shiftReg[DATA_W-1:AMT_W];

  always_comb begin
    if (useImm) begin
      shInValue = DATA_W'(immField[CONST_W-1:0]);
      shAmount  = AMT_W'({immField[ROT_W+CONST_W-1:CONST_W], 1'b0});
      shKind    = SH_ROR;
    end else begin
      shInValue = opB;
      shAmount  = shiftByReg ? shiftReg[AMT_W-1:0] : AMT_W'(shiftImm);
      shKind    = shiftType;
    end
  end

  pred_alu_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) shifter_i (
    .value    (shInValue),
    .amount   (shAmount),
    .kind     (shKind),
    .carryIn  (flagsQ[FLAG_C]),
    .shifted  (operand2),
    .carryOut (shCarry)
  );

  always_comb begin
    addX = strobes.swapOps ? operand2 : opA;
    addY = strobes.swapOps ? opA : operand2;
    if (strobes.invertB) addY = ~addY;
    unique case (strobes.carrySel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = flagsQ[FLAG_C];
      default:  addCin = 1'b0;
    endcase
    sum = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, addCin};
    ovf = (addX[MSB] == addY[MSB]) && (sum[MSB] != addX[MSB]);
  end

  always_comb begin
    unique case (strobes.logicFn)
      LF_AND:  logicRes = opA & operand2;
      LF_ORR:  logicRes = opA | operand2;
      LF_EOR:  logicRes = opA ^ operand2;
      LF_BIC:  logicRes = opA & ~operand2;
      LF_PASS: logicRes = operand2;
      LF_INV:  logicRes = ~operand2;
      default: logicRes = operand2;
    endcase
  end

  assign result = strobes.useAdder ? sum[MSB:0] : logicRes;
  assign newC   = strobes.useAdder ? sum[DATA_W] : shCarry;
  assign newV   = strobes.useAdder ? ovf : flagsQ[FLAG_V];
  assign flagsD = {result[MSB], (result == '0), newC, newV};

  always_ff @(posedge clk) begin
    if (!rstN)                    flagsQ <= '0;
    else if (strobes.updateFlags) flagsQ <= flagsD;
  end

endmodule

// File: rtl/pred_alu.sv
module pred_alu #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        condIn,
  input  logic [3:0]        opcode,
  input  logic              setFlags,
  input  logic [DATA_W-1:0] opA,
  input  logic              useImm,
  input  logic [11:0]       immField,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        shiftType,
  input  logic              shiftByReg,
  input  logic [4:0]        shiftImm,
  input  logic [DATA_W-1:0] shiftReg,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flags
);
  import pred_alu_pkg::*;

  aluStrobes_t strobes;

  pred_alu_ctrl ctrl_i (
    .instValid (instValid),
    .condIn    (condIn),
    .opcode    (opcode),
    .setFlags  (setFlags),
    .flagsQ    (flags),
    .strobes   (strobes)
  );

  pred_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opA        (opA),
    .useImm     (useImm),
    .immField   (immField),
    .opB        (opB),
    .shiftType  (shiftType),
    .shiftByReg (shiftByReg),
    .shiftImm   (shiftImm),
    .shiftReg   (shiftReg),
    .result     (result),
    .flagsQ     (flags)
  );

  assign writeEn = strobes.writeDest;

endmodule

// File: rtl/pred_alu_chk.sv
module pred_alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [3:0]        condIn,
  input logic [3:0]        opcode,
  input logic              setFlags,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [3:0]        flags
);

  logic isCmp;
  assign isCmp = (opcode >= 4'd10) && (opcode <= 4'd13);

  // R1
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !writeEn);
  p_idle_flags_r1: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> $stable(flags));

  // R2: condition 15 never passes
  p_never_r2: assert property (@(posedge clk) disable iff (!rstN)
    (condIn == 4'hF) |-> !writeEn);

  // R3: EQ with Z clear fails
  p_fail_nowrite_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condIn == 4'd0 && !flags[2]) |-> !writeEn);
  p_fail_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condIn == 4'd0 && !flags[2]) |=> $stable(flags));

  // R5
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |-> !writeEn);

  // R6
  p_noset_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!setFlags && !isCmp) |=> $stable(flags));

  // R7
  p_nz_r7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condIn == 4'd14 && (setFlags || isCmp)) |=>
      (flags[3] == $past(result[DATA_W-1])) && (flags[2] == ($past(result) == '0)));

  // R9: logical ops keep V
  p_logic_v_r9: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode >= 4'd6 && opcode != 4'd10 && opcode != 4'd11) |=>
      (flags[0] == $past(flags[0])));

endmodule

bind pred_alu pred_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .condIn    (condIn),
  .opcode    (opcode),
  .setFlags  (setFlags),
  .result    (result),
  .writeEn   (writeEn),
  .flags     (flags)
);

// File: tb/pred_alu_tb_top.sv
module pred_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  condIn = '0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic [31:0] opA = '0;
  logic        useImm = 1'b0;
  logic [11:0] immField = '0;
  logic [31:0] opB = '0;
  logic [1:0]  shiftType = '0;
  logic        shiftByReg = 1'b0;
  logic [4:0]  shiftImm = '0;
  logic [31:0] shiftReg = '0;
  logic [31:0] result;
  logic        writeEn;
  logic [3:0]  flags;

  int checks = 0;
  int failures = 0;
  logic [3:0] modelFlags = 4'b0000;

  always #10 clk = ~clk;

  pred_alu dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .condIn(condIn),
    .opcode(opcode), .setFlags(setFlags), .opA(opA), .useImm(useImm),
    .immField(immField), .opB(opB), .shiftType(shiftType),
    .shiftByReg(shiftByReg), .shiftImm(shiftImm), .shiftReg(shiftReg),
    .result(result), .writeEn(writeEn), .flags(flags)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: operand, condition and arithmetic from the requirements.
  task automatic model(output logic [31:0] r, output logic we, output logic [3:0] nf);
    logic n, z, c, v, pass, sc, nc, nv, cmp, upd;
    logic [31:0] b;
    int amt, rot;
    longint unsigned ua, ub, s;
    longint sa, sb, ss;
    bit arith;
    {n, z, c, v} = modelFlags;
    case (condIn)
      0: pass = z;           1: pass = !z;
      2: pass = c;           3: pass = !c;
      4: pass = n;           5: pass = !n;
      6: pass = v;           7: pass = !v;
      8: pass = c && !z;     9: pass = !c || z;
      10: pass = n == v;     11: pass = n != v;
      12: pass = !z && n == v; 13: pass = z || n != v;
      14: pass = 1'b1;       default: pass = 1'b0;
    endcase
    if (useImm) begin
      rot = 2 * int'(immField[11:8]);
      b = 32'(immField[7:0]);
      if (rot != 0) b = (b >> rot) | (b << (32 - rot));
      sc = (rot == 0) ? c : b[31];
    end else begin
      amt = shiftByReg ? int'(shiftReg[7:0]) : int'(shiftImm);
      b = opB; sc = c;
      if (amt != 0) begin
        case (shiftType)
          2'd0: if (amt < 32) begin b = opB << amt; sc = opB[32-amt]; end
                else if (amt == 32) begin b = 0; sc = opB[0]; end
                else begin b = 0; sc = 0; end
          2'd1: if (amt < 32) begin b = opB >> amt; sc = opB[amt-1]; end
                else if (amt == 32) begin b = 0; sc = opB[31]; end
                else begin b = 0; sc = 0; end
          2'd2: if (amt < 32) begin b = 32'($signed(opB) >>> amt); sc = opB[amt-1]; end
                else begin b = {32{opB[31]}}; sc = opB[31]; end
          default: begin
            rot = amt % 32;
            if (rot == 0) begin b = opB; sc = opB[31]; end
            else begin b = (opB >> rot) | (opB << (32 - rot)); sc = opB[rot-1]; end
          end
        endcase
      end
    end
    ua = 64'(opA); ub = 64'(b);
    sa = longint'($signed(opA)); sb = longint'($signed(b));
    arith = 1'b1; s = 0; ss = 0; r = 0;
    case (opcode)
      0, 11: begin s = ua + ub; ss = sa + sb; end
      1: begin s = ua + ub + 64'(c); ss = sa + sb + longint'(c); end
      2, 10: begin s = ua + (ub ^ 64'hFFFF_FFFF) + 1; ss = sa - sb; end
      3: begin s = ua + (ub ^ 64'hFFFF_FFFF) + 64'(c); ss = sa - sb - 1 + longint'(c); end
      4: begin s = ub + (ua ^ 64'hFFFF_FFFF) + 1; ss = sb - sa; end
      5: begin s = ub + (ua ^ 64'hFFFF_FFFF) + 64'(c); ss = sb - sa - 1 + longint'(c); end
      6, 12: begin arith = 0; r = opA & b; end
      7: begin arith = 0; r = opA | b; end
      8, 13: begin arith = 0; r = opA ^ b; end
      9: begin arith = 0; r = opA & ~b; end
      14: begin arith = 0; r = b; end
      default: begin arith = 0; r = ~b; end
    endcase
    if (arith) begin
      r = s[31:0]; nc = s[32];
      nv = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end else begin
      nc = sc; nv = v;
    end
    cmp = (opcode >= 10) && (opcode <= 13);
    we  = instValid && pass && !cmp;
    upd = instValid && pass && (setFlags || cmp);
    nf  = upd ? {r[31], r == 32'd0, nc, nv} : modelFlags;
  endtask

  task automatic exec(string tag);
    logic [31:0] eRes; logic eWe; logic [3:0] eNext;
    #5;
    model(eRes, eWe, eNext);
    if (instValid) chk(tag, "result", result, eRes);
    chk(tag, "writeEn", 32'(writeEn), 32'(eWe));
    chk(tag, "flags", 32'(flags), 32'(modelFlags));
    @(posedge clk); #1;
    modelFlags = eNext;
  endtask

  task automatic opI(string tag, int c, int op, bit s, logic [31:0] a, logic [11:0] imm);
    @(negedge clk);
    instValid = 1; condIn = 4'(c); opcode = 4'(op); setFlags = s; opA = a;
    useImm = 1; immField = imm;
    exec(tag);
  endtask

  task automatic opR(string tag, int c, int op, bit s, logic [31:0] a, logic [31:0] b,
                     int st, bit byReg, int samt, logic [31:0] sreg);
    @(negedge clk);
    instValid = 1; condIn = 4'(c); opcode = 4'(op); setFlags = s; opA = a;
    useImm = 0; opB = b; shiftType = 2'(st); shiftByReg = byReg;
    shiftImm = 5'(samt); shiftReg = sreg;
    exec(tag);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R13", "reset flags", 32'(flags), 32'h0);
    chk("R13", "reset writeEn", 32'(writeEn), 32'h0);

    // R7 / R8 arithmetic corners
    opR("R7", 14, 14, 1, 0, 0, 0, 0, 0, 0);
    opR("R8", 14, 0, 1, 32'h7FFF_FFFF, 1, 0, 0, 0, 0);
    opR("R8", 14, 2, 1, 5, 5, 0, 0, 0, 0);
    opR("R8", 14, 2, 1, 3, 5, 0, 0, 0, 0);
    opR("R8", 14, 2, 1, 32'h8000_0000, 1, 0, 0, 0, 0);
    opR("R8", 14, 11, 0, 32'hFFFF_FFFF, 1, 0, 0, 0, 0);
    opR("R8", 14, 1, 1, 32'h10, 32'h20, 0, 0, 0, 0);
    opR("R8", 14, 3, 1, 32'h10, 32'h20, 0, 0, 0, 0);
    opR("R8", 14, 4, 1, 7, 3, 0, 0, 0, 0);
    opR("R8", 14, 5, 1, 3, 7, 0, 0, 0, 0);
    opR("R5", 14, 10, 0, 9, 9, 0, 0, 0, 0);
    opR("R5", 14, 12, 0, 32'hF0, 32'h0F, 0, 0, 0, 0);
    opR("R5", 14, 13, 0, 32'hAA, 32'hAA, 0, 0, 0, 0);

    // R4: MOV and MVN ignore opA
    opR("R4", 14, 14, 0, 32'h1234_5678, 32'hCAFE, 0, 0, 0, 0);
    opR("R4", 14, 14, 0, 32'hFFFF_FFFF, 32'hCAFE, 0, 0, 0, 0);
    opR("R4", 14, 15, 0, 32'hDEAD_BEEF, 32'h0F0F, 0, 0, 0, 0);
    opR("R4", 14, 9, 1, 32'hFFFF_FFFF, 32'hFF, 0, 0, 0, 0);

    // R6: no set-flags means no update
    opR("R6", 14, 2, 0, 0, 1, 0, 0, 0, 0);
    opR("R6", 14, 2, 1, 0, 1, 0, 0, 0, 0);
    opR("R6", 14, 0, 0, 0, 0, 0, 0, 0, 0);

    // R3: failing predicate with S set
    opR("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    opR("R3", 15, 14, 1, 0, 0, 0, 0, 0, 0);

    // R1: idle cycle
    @(negedge clk);
    instValid = 0; condIn = 14; opcode = 2; setFlags = 1;
    exec("R1");

    // R10: immediate rotation
    opI("R10", 14, 14, 1, 0, 12'h4FF);
    opI("R10", 14, 14, 1, 0, 12'h0FF);
    opI("R10", 14, 14, 1, 0, 12'hF01);
    opI("R10", 14, 14, 1, 0, 12'h181);

    // R11: immediate shift amounts, R12: register amounts
    for (int t = 0; t < 4; t++) begin
      opR("R11", 14, 14, 1, 0, 32'h8000_0001, t, 0, 0, 0);
      opR("R11", 14, 14, 1, 0, 32'h8000_0001, t, 0, 1, 0);
      opR("R11", 14, 14, 1, 0, 32'hC000_0003, t, 0, 31, 0);
      opR("R12", 14, 14, 1, 0, 32'h8000_0001, t, 1, 0, 32'h0000_0100);
      opR("R12", 14, 14, 1, 0, 32'h8000_0001, t, 1, 0, 32'hFF00_0020);
      opR("R12", 14, 14, 1, 0, 32'h8000_0001, t, 1, 0, 33);
      opR("R12", 14, 14, 1, 0, 32'h8000_0003, t, 1, 0, 64);
      opR("R12", 14, 14, 1, 0, 32'h8000_0003, t, 1, 0, 255);
      opR("R12", 14, 14, 1, 0, 32'h4000_0003, t, 1, 0, 32'h0000_0101);
    end

    // R2: every predicate against many flag states
    for (int k = 0; k < 24; k++) begin
      for (int cc = 0; cc < 16; cc++) begin
        opR("R2", 14, 10, 0, $urandom, (k % 3 == 0) ? $urandom : 32'(k), 0, 0, 0, 0);
        opR("R2", cc, 14, 0, 0, 32'(cc + 1), 0, 0, 0, 0);
      end
    end

    // R9 and general mix: random instructions
    for (int k = 0; k < 600; k++) begin
      if (k % 2 == 0)
        opR("R9", $urandom % 16, $urandom % 16, 1'($urandom), $urandom,
            (k % 8 == 0) ? 32'h8000_0000 : $urandom, $urandom % 4,
            1'($urandom), $urandom % 32, $urandom % 80);
      else
        opI("R8", $urandom % 16, $urandom % 16, 1'($urandom), $urandom, 12'($urandom));
    end

    @(negedge clk);
    instValid = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule